// File: doc/BRIEF.md
# Count-Enable Prescaler and Pin Filter

This stage sits in front of a low-power event counter and decides when the counter may advance. It watches one of several slow clock sources, chosen by a select input. Each source is treated as a level sampled in the system clock domain, and every rising edge of the chosen source counts as one tick. In time mode the ticks go through a power-of-two divider. In pulse mode they clock a stability filter on an external pin instead. A single 4-bit ratio input sets both the divide length and the filter length, so one setting gives the two related powers of two.

When the bypass input is set, the divider and the filter are skipped. Each tick, or each rising edge of the raw pin, then goes straight to the output. The output is a one-cycle count-enable pulse in the system clock domain. A ratio of zero is not a valid filter setting, so the stage raises an error flag and stays silent in that case. Any change of mode, bypass, source select or ratio while the stage is enabled clears the divider and filter counts.

Top module: `cnt_front`

## Requirements
- R1: While reset is active, and in the first cycle after it, `cnt_en_o` and `cfg_err_o` are 0.
- R2: In time mode with bypass clear and ratio value P, `cnt_en_o` pulses on every 2^(P+1)-th tick after the last clear. The pulse appears in the cycle after the clock edge at which the tick is sampled.
- R3: A tick is a 0-to-1 change of `clk_src_i[src_sel_i]` between two samples. Edges on sources that are not selected have no effect.
- R4: In pulse mode with bypass clear and P of 1 or more, the accepted pin level takes a new value only after the pin has differed from it on 2^P consecutive ticks. A pulse is issued only when the accepted level goes from 0 to 1, at the accepting tick.
- R5: A tick on which the pin equals the accepted level restarts the filter's stability count from zero.
- R6: With the stage enabled, pulse mode, bypass clear and P = 0, `cfg_err_o` is 1 and no pulse is issued. In every other case `cfg_err_o` is 0.
- R7: In time mode with bypass set, every tick gives a pulse.
- R8: In pulse mode with bypass set, each 0-to-1 change of `pin_i` gives a pulse in the next cycle, and ticks have no effect.
- R9: In a cycle where the enabled stage sees mode, bypass, select or ratio differ from the previous cycle, no event is taken and the divider and filter counts are cleared.
- R10: While `enable_i` is 0, no pulse is issued, the counts are held at zero, and the accepted pin level follows `pin_i`.
- R11: `cnt_en_o` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Stage enable |
| mode_i | input | 1 | 0 = time (divider), 1 = pulse (pin filter) |
| bypass_i | input | 1 | 1 = skip the divider and the filter |
| src_sel_i | input | SEL_W (2) | Tick source select |
| ratio_i | input | RATIO_W (4) | Power-of-two length code P |
| clk_src_i | input | NUM_SRC (4) | Sampled tick sources |
| pin_i | input | 1 | Sampled pin to be filtered |
| cnt_en_o | output | 1 | One-cycle count-enable pulse |
| cfg_err_o | output | 1 | Invalid filter setting (P = 0) |

## Verification
A configuration change and a tick on the selected source can land in the same cycle. The design must then drop the tick and clear its count. The bench provokes this by raising the source in the same cycle that the ratio changes. It then checks that the next pulse comes only after a full new period, counted from the following tick. A second collision happens when the pin returns to its accepted level partway through a stability count. The bench judges this by the exact tick on which the later pulse appears.

// File: rtl/cnt_front_pkg.sv
package cnt_front_pkg;
  typedef enum logic {
    MODE_TIME  = 1'b0,
    MODE_PULSE = 1'b1
  } cf_mode_e;
endpackage

// File: rtl/cf_rise_det.sv
module cf_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end
  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/cf_divider.sv
module cf_divider #(
  parameter int RATIO_W = 4,
  localparam int DIV_W  = 1 << RATIO_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               clear_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               term_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   lim_w;
  logic [RATIO_W:0] shamt;

  // terminal value is 2^(P+1)-1
  assign shamt  = {1'b0, ratio_i} + {{RATIO_W{1'b0}}, 1'b1};
  assign lim_w  = ({{DIV_W{1'b0}}, 1'b1} << shamt) - {{DIV_W{1'b0}}, 1'b1};
  assign term_o = tick_i & (cnt_q == lim_w[DIV_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= term_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cf_filter.sv
module cf_filter #(
  parameter int RATIO_W = 4,
  localparam int DIV_W  = 1 << RATIO_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               clear_i,
  input  logic               follow_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               pin_i,
  output logic               rise_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim_w;
  logic             acc_q;
  logic             differs;
  logic             done;

  assign lim_w   = ({{(DIV_W-1){1'b0}}, 1'b1} << ratio_i) - {{(DIV_W-1){1'b0}}, 1'b1};
  assign differs = pin_i ^ acc_q;
  assign done    = tick_i & ~clear_i & ~follow_i & differs & (cnt_q == lim_w);
  assign rise_o  = done & pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else if (follow_i) begin
      cnt_q <= '0;
      acc_q <= pin_i;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (!differs) cnt_q <= '0;   // pin back at accepted level: restart
      else if (done) begin
        cnt_q <= '0;
        acc_q <= pin_i;
      end else cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cnt_front.sv
module cnt_front
  import cnt_front_pkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int RATIO_W  = 4,
  localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               mode_i,
  input  logic               bypass_i,
  input  logic [SEL_W-1:0]   src_sel_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [NUM_SRC-1:0] clk_src_i,
  input  logic               pin_i,
  output logic               cnt_en_o,
  output logic               cfg_err_o
);
  localparam int CFG_W = 2 + SEL_W + RATIO_W;

  logic [CFG_W-1:0] cfg_w, cfg_q;
  logic             cfg_chg;
  logic             pulse_mode;
  logic             src_rise, pin_rise, tick;
  logic             div_term, filt_rise;
  logic             evt;
  logic             cnt_en_q;

  assign pulse_mode = (cf_mode_e'(mode_i) == MODE_PULSE);
  assign cfg_w      = {mode_i, bypass_i, src_sel_i, ratio_i};
  assign cfg_chg    = enable_i & (cfg_w != cfg_q);
  assign cfg_err_o  = enable_i & pulse_mode & ~bypass_i & (ratio_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_w;
  end

  cf_rise_det u_src_rise (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .sig_i (clk_src_i[src_sel_i]), .rise_o(src_rise)
  );

  cf_rise_det u_pin_rise (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .sig_i (pin_i), .rise_o(pin_rise)
  );

  assign tick = src_rise & enable_i & ~cfg_chg;

  cf_divider #(.RATIO_W(RATIO_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick & ~pulse_mode & ~bypass_i),
    .clear_i(~enable_i | cfg_chg),
    .ratio_i(ratio_i),
    .term_o (div_term)
  );

  cf_filter #(.RATIO_W(RATIO_W)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick & pulse_mode & ~bypass_i),
    .clear_i (cfg_chg),
    .follow_i(~enable_i),
    .ratio_i (ratio_i),
    .pin_i   (pin_i),
    .rise_o  (filt_rise)
  );

  always_comb begin
    unique case ({pulse_mode, bypass_i})
      2'b00:   evt = div_term;
      2'b01:   evt = tick;
      2'b10:   evt = filt_rise & ~cfg_err_o;
      default: evt = pin_rise & ~cfg_chg;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_en_q <= 1'b0;
    else         cnt_en_q <= enable_i & evt;
  end

  assign cnt_en_o = cnt_en_q;
endmodule

// File: rtl/cnt_front_chk.sv
module cnt_front_chk #(
  parameter int NUM_SRC = 4,
  parameter int RATIO_W = 4,
  parameter int SEL_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic               mode_i,
  input logic               bypass_i,
  input logic [SEL_W-1:0]   src_sel_i,
  input logic [RATIO_W-1:0] ratio_i,
  input logic [NUM_SRC-1:0] clk_src_i,
  input logic               pin_i,
  input logic               cnt_en_o,
  input logic               cfg_err_o
);
  assert_single_cycle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_o |=> !cnt_en_o);

  assert_quiet_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !cnt_en_o);

  assert_quiet_on_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> !cnt_en_o);

  assert_drop_on_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && ratio_i != $past(ratio_i)) |=> !cnt_en_o);

  assert_bypass_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && bypass_i && !mode_i && $stable(mode_i) && $stable(bypass_i) &&
     $stable(src_sel_i) && $stable(ratio_i) &&
     clk_src_i[src_sel_i] && !$past(clk_src_i[src_sel_i])) |=> cnt_en_o);

  assert_bypass_pin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && bypass_i && mode_i && $stable(mode_i) && $stable(bypass_i) &&
     $stable(src_sel_i) && $stable(ratio_i) && pin_i && !$past(pin_i)) |=> cnt_en_o);
endmodule

bind cnt_front cnt_front_chk #(.NUM_SRC(NUM_SRC), .RATIO_W(RATIO_W), .SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .mode_i(mode_i),
  .bypass_i(bypass_i), .src_sel_i(src_sel_i), .ratio_i(ratio_i),
  .clk_src_i(clk_src_i), .pin_i(pin_i), .cnt_en_o(cnt_en_o), .cfg_err_o(cfg_err_o)
);

// File: tb/tb_cnt_front.sv
module tb_cnt_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, mode = 1'b0, byp = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [3:0] ratio = 4'd0;
  logic [3:0] src = 4'd0;
  logic       pin = 1'b0;
  logic       cnt_en, cfg_err;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  int    exp_cyc[$];
  string exp_req[$];
  bit    done = 1'b0;

  cnt_front dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .mode_i(mode), .bypass_i(byp),
    .src_sel_i(sel), .ratio_i(ratio), .clk_src_i(src), .pin_i(pin),
    .cnt_en_o(cnt_en), .cfg_err_o(cfg_err)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  // monitor: every pulse must match the head of the expectation queue
  always @(negedge clk) begin
    if (rst_n && !done && cnt_en) begin
      checks++;
      if (exp_cyc.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected pulse at cycle %0d, expected none", cur_req, cyc);
      end else begin
        int    c;
        string r;
        c = exp_cyc.pop_front();
        r = exp_req.pop_front();
        if (c != cyc) begin
          fails++;
          $display("FAIL %s pulse at cycle %0d, expected cycle %0d", r, cyc, c);
        end
      end
    end
  end

  task automatic check_val(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    while (exp_cyc.size() != 0) begin
      int    c;
      string r;
      c = exp_cyc.pop_front();
      r = exp_req.pop_front();
      checks++;
      fails++;
      $display("FAIL %s missing pulse, actual none expected cycle %0d", r, c);
    end
  endtask

  task automatic push(input bit want, input string req);
    if (want) begin
      exp_cyc.push_back(cyc + 1);
      exp_req.push_back(req);
    end
  endtask

  task automatic set_cfg(input logic e, input logic m, input logic b,
                         input logic [1:0] s, input logic [3:0] p);
    @(negedge clk);
    en = e; mode = m; byp = b; sel = s; ratio = p;
    @(negedge clk);
  endtask

  // one rising edge on source idx
  task automatic tick_src(input int idx, input bit want, input string req);
    @(negedge clk);
    src[idx] = 1'b1;
    push(want, req);
    @(negedge clk);
    src[idx] = 1'b0;
  endtask

  task automatic set_pin(input logic v, input bit want, input string req);
    @(negedge clk);
    pin = v;
    push(want, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_val("R1 cnt_en in reset", int'(cnt_en), 0);
    check_val("R1 cfg_err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_val("R1 cnt_en after reset", int'(cnt_en), 0);
    check_val("R1 cfg_err after reset", int'(cfg_err), 0);

    // R2: time mode dividers
    cur_req = "R2";
    set_cfg(1, 0, 0, 2'd0, 4'd0);
    for (int i = 1; i <= 4; i++) tick_src(0, (i % 2) == 0, "R2 div2");
    set_cfg(1, 0, 0, 2'd0, 4'd2);
    for (int i = 1; i <= 16; i++) tick_src(0, (i % 8) == 0, "R2 div8");
    drain();

    // R3: unselected sources ignored
    cur_req = "R3";
    set_cfg(1, 0, 0, 2'd0, 4'd0);
    tick_src(0, 0, "R3");
    for (int i = 0; i < 3; i++) tick_src(1, 0, "R3");
    tick_src(3, 0, "R3");
    tick_src(0, 1, "R3 selected source");
    set_cfg(1, 0, 0, 2'd2, 4'd0);
    tick_src(0, 0, "R3");
    tick_src(2, 0, "R3");
    tick_src(2, 1, "R3 source 2");
    drain();

    // R9: config change clears count
    cur_req = "R9";
    set_cfg(1, 0, 0, 2'd0, 4'd1);
    for (int i = 0; i < 3; i++) tick_src(0, 0, "R9");
    set_cfg(1, 0, 0, 2'd0, 4'd2);
    for (int i = 1; i <= 8; i++) tick_src(0, i == 8, "R9 cleared by ratio change");
    // collision: ratio change and tick in the same cycle
    set_cfg(1, 0, 0, 2'd0, 4'd0);
    tick_src(0, 0, "R9");
    @(negedge clk);
    ratio = 4'd1;
    src[0] = 1'b1;
    @(negedge clk);
    src[0] = 1'b0;
    for (int i = 1; i <= 4; i++) tick_src(0, i == 4, "R9 tick dropped on change");
    drain();

    // R4: filter accept and pulse on rising only
    cur_req = "R4";
    set_cfg(1, 1, 0, 2'd0, 4'd1);
    check_val("R6 no error at P=1", int'(cfg_err), 0);
    set_pin(1, 0, "R4");
    tick_src(0, 0, "R4");
    tick_src(0, 1, "R4 rise after 2 ticks");
    set_pin(0, 0, "R4");
    tick_src(0, 0, "R4");
    tick_src(0, 0, "R4 fall gives no pulse");
    set_cfg(1, 1, 0, 2'd0, 4'd2);
    set_pin(1, 0, "R4");
    for (int i = 1; i <= 4; i++) tick_src(0, i == 4, "R4 rise after 4 ticks");
    drain();

    // R5: restart on return to accepted level
    cur_req = "R5";
    set_pin(0, 0, "R5");
    for (int i = 0; i < 4; i++) tick_src(0, 0, "R5");
    set_pin(1, 0, "R5");
    for (int i = 0; i < 3; i++) tick_src(0, 0, "R5");
    set_pin(0, 0, "R5");
    tick_src(0, 0, "R5");
    set_pin(1, 0, "R5");
    for (int i = 1; i <= 4; i++) tick_src(0, i == 4, "R5 restarted count");
    drain();

    // R6: P=0 filter is invalid
    cur_req = "R6";
    set_cfg(1, 1, 0, 2'd0, 4'd0);
    check_val("R6 error flag", int'(cfg_err), 1);
    set_pin(0, 0, "R6");
    tick_src(0, 0, "R6"); tick_src(0, 0, "R6");
    set_pin(1, 0, "R6");
    tick_src(0, 0, "R6"); tick_src(0, 0, "R6");
    set_cfg(1, 1, 1, 2'd0, 4'd0);
    check_val("R6 no error in bypass", int'(cfg_err), 0);
    set_cfg(0, 1, 0, 2'd0, 4'd0);
    check_val("R6 no error when disabled", int'(cfg_err), 0);
    drain();

    // R8: bypass pulse mode
    cur_req = "R8";
    set_cfg(1, 1, 1, 2'd0, 4'd1);
    set_pin(0, 0, "R8");
    set_pin(1, 1, "R8 direct pin rise");
    tick_src(0, 0, "R8"); tick_src(0, 0, "R8");
    set_pin(0, 0, "R8");
    set_pin(1, 1, "R8 second rise");
    drain();

    // R7: bypass time mode
    cur_req = "R7";
    set_cfg(1, 0, 1, 2'd0, 4'd3);
    for (int i = 0; i < 3; i++) tick_src(0, 1, "R7 every tick");
    drain();

    // R10: disabled
    cur_req = "R10";
    set_cfg(0, 1, 0, 2'd0, 4'd1);
    set_pin(0, 0, "R10");
    tick_src(0, 0, "R10"); tick_src(0, 0, "R10");
    set_pin(1, 0, "R10");
    tick_src(0, 0, "R10"); tick_src(0, 0, "R10");
    check_val("R10 no pulse while off", int'(cnt_en), 0);
    set_cfg(1, 1, 0, 2'd0, 4'd1);
    tick_src(0, 0, "R10 level followed"); tick_src(0, 0, "R10 level followed");
    set_pin(0, 0, "R10");
    tick_src(0, 0, "R10"); tick_src(0, 0, "R10");
    set_pin(1, 0, "R10");
    tick_src(0, 0, "R10"); tick_src(0, 1, "R10 filter after enable");
    set_cfg(1, 0, 0, 2'd0, 4'd1);
    tick_src(0, 0, "R10"); tick_src(0, 0, "R10");
    set_cfg(0, 0, 0, 2'd0, 4'd1);
    tick_src(0, 0, "R10"); tick_src(0, 0, "R10");
    set_cfg(1, 0, 0, 2'd0, 4'd1);
    for (int i = 1; i <= 4; i++) tick_src(0, i == 4, "R10 divider cleared");
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule